// File: doc/BRIEF.md
# Packet-Command Device Register Controller

This block is the device end of a parallel storage port that speaks the packet-command protocol. A host reaches a small bank of byte-wide registers and one 16-bit data port through a register interface. The registers are status, error, feature, sector count, byte count low and high, device select and device control. The block runs the command sequence. A packet command opens a six-word window for the 12-byte command packet. The captured packet then goes to a downstream decoder with a one-cycle strobe. The decoder answers with either a programmed-I/O read or a DMA read of a given byte length, and the block serves that transfer from an internal sector buffer.

The sector buffer is filled beforehand through a separate loader port. PIO reads step through the buffer one word per data-port read. An interrupt is raised at every block boundary the host set up, and again at the end of the transfer. DMA reads are requested in chunks. Each request is granted the smaller of the asked and the remaining byte count. A done pulse marks the last chunk. A single interrupt line reflects a pending latch gated by a mask bit in the device-control register.

Top module: `atapi_dev_ctrl`

## Requirements
- R1: After reset, status (address 6) reads 0x50, error (address 1) and device (address 5) read 0, and `intrq` is low.
- R2: Writing 0xA0 to the command register (address 6) gives status 0x48, sector count 0x01, and an error register equal to feature bits 1:0.
- R3: In the packet window the sixth data-port write (address 0) makes status 0xC0. `pkt_valid` is then high for exactly one cycle with packet word k on `pkt_data[16k+15:16k]`.
- R4: A `rsp_pio` response while busy gives status 0x48, sector count 0x02 and byte count {address 4, address 3} equal to `rsp_len`, and raises an interrupt. The previous byte-count value becomes the block length.
- R5: Each PIO data read returns buffer word offset/2, with the offset starting at 0 and advancing by 2. An interrupt is raised when the bytes read since the last boundary reach the block length, unless the transfer ends on that read.
- R6: The read that reaches `rsp_len` bytes clears DRQ (status 0x40), returns to idle and raises an interrupt.
- R7: A `rsp_dma` response gives status 0xD0 and raises an interrupt. Each `dma_req` is granted min(`dma_req_len`, remaining bytes) on `dma_grant_len` in the next cycle. The last grant sets status 0x50, returns to idle, raises an interrupt and pulses `dma_done` for one cycle.
- R8: A status read clears the pending interrupt only when status bit 7 (BSY) is 0.
- R9: `intrq` is high exactly when an interrupt is pending and control bit 1 (address 7) is 0. Changing that bit changes `intrq` in the next cycle.
- R10: Any command write first clears the pending interrupt. Command 0x00 aborts any transfer, goes idle, sets status 0x51 and raises an interrupt.
- R11: Any other command code sets status bits 6 and 4 and clears bit 0, leaving no interrupt pending.
- R12: Data-port accesses outside the packet window (writes) or the PIO read state (reads) change nothing, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (side effects on the clock edge) |
| reg_addr | input | 3 | Register address: 0 data, 1 error/feature, 2 count, 3 byte count low, 4 byte count high, 5 device, 6 status/command, 7 control |
| reg_wdata | input | 16 | Host write data (registers use bits 7:0) |
| reg_rdata | output | 16 | Host read data, combinational while reg_rd is high |
| ld_we | input | 1 | Sector buffer load strobe |
| ld_addr | input | 6 | Sector buffer word address |
| ld_data | input | 16 | Sector buffer load word |
| pkt_valid | output | 1 | One-cycle strobe: command packet captured |
| pkt_data | output | 96 | Captured 12-byte packet, word 0 in the low bits |
| rsp_pio | input | 1 | Decoder response: start a PIO read |
| rsp_dma | input | 1 | Decoder response: start a DMA read |
| rsp_len | input | 16 | Byte length of the started read (even, non-zero) |
| dma_req | input | 1 | DMA chunk request |
| dma_req_len | input | 16 | Requested chunk size in bytes |
| dma_grant_len | output | 16 | Bytes granted to the last request (0 outside DMA) |
| dma_done | output | 1 | One-cycle pulse on the final DMA grant |
| intrq | output | 1 | Interrupt request line |

## Verification
The bench aims at block boundaries inside a PIO read where the length is not a multiple of the block. A design that reloaded the block counter on the last read would raise an extra boundary interrupt there, and one that compared against the wrong counter would miss the middle boundaries. It reads status while a DMA read is in flight. A controller that cleared the latch regardless of BSY would drop `intrq` at that point. It asks for a DMA chunk longer than what remains, so a missing clamp shows as an oversized grant and no done pulse. It also toggles the mask bit while an interrupt is pending and pokes the data port in idle: a design that wired the mask wrongly would keep the line stuck, and one that accepted stray accesses would shorten the next packet window.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int BC_W      = 16;
  localparam int PKT_BYTES = 12;
  localparam int PKT_WORDS = PKT_BYTES / 2;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_ERR  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_BCL  = 3'd3;
  localparam logic [2:0] A_BCH  = 3'd4;
  localparam logic [2:0] A_DEV  = 3'd5;
  localparam logic [2:0] A_CMD  = 3'd6;
  localparam logic [2:0] A_CTL  = 3'd7;

  localparam logic [7:0] OP_ABORT  = 8'h00;
  localparam logic [7:0] OP_PACKET = 8'hA0;

  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_SERV = 8'h10;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_CHK  = 8'h01;

  localparam logic [7:0] CNT_COD = 8'h01;
  localparam logic [7:0] CNT_IO  = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_CMDW, S_BUSY, S_PIO, S_DMA
  } adc_state_e;

  function automatic logic [BC_W-1:0] adc_grant(input logic [BC_W-1:0] want,
                                                input logic [BC_W-1:0] left);
    return (want < left) ? want : left;
  endfunction

  function automatic logic [7:0] adc_unimpl_status(input logic [7:0] cur);
    return (cur | ST_DRDY | ST_SERV) & ~ST_CHK;
  endfunction

  function automatic logic adc_reached(input logic [BC_W-1:0] ofs,
                                       input logic [BC_W-1:0] step,
                                       input logic [BC_W-1:0] total);
    return ({1'b0, ofs} + {1'b0, step}) >= {1'b0, total};
  endfunction
endpackage

// File: rtl/adc_sector_buf.sv
module adc_sector_buf #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data
);
  logic [15:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic mask,
  output logic pending,
  output logic set_edge,
  output logic line
);
  logic pend_q;

  assign set_edge = raise && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (set_edge) pend_q <= 1'b1;
    else if (raise)    pend_q <= pend_q;
    else if (clear)    pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign line    = pend_q && !mask;
endmodule

// File: rtl/atapi_dev_ctrl.sv
module atapi_dev_ctrl
  import adc_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  localparam int AW = $clog2(BUF_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic                 ld_we,
  input  logic [AW-1:0]        ld_addr,
  input  logic [15:0]          ld_data,
  output logic                 pkt_valid,
  output logic [PKT_BYTES*8-1:0] pkt_data,
  input  logic                 rsp_pio,
  input  logic                 rsp_dma,
  input  logic [BC_W-1:0]      rsp_len,
  input  logic                 dma_req,
  input  logic [BC_W-1:0]      dma_req_len,
  output logic [BC_W-1:0]      dma_grant_len,
  output logic                 dma_done,
  output logic                 intrq
);
  localparam logic [BC_W-1:0] TWO = BC_W'(2);

  adc_state_e      state_q;
  logic [7:0]      status_q, error_q, feature_q, count_q;
  logic [7:0]      bcl_q, bch_q, device_q, ctrl_q;
  logic [BC_W-1:0] ofs_q, len_q, blk_len_q, blk_left_q;
  logic [15:0]     pkt_q [PKT_WORDS];
  logic            pkt_valid_q, dma_done_q;
  logic [BC_W-1:0] grant_q;

  // named events
  logic host_cmd, ev_abort, ev_packet, ev_unimpl;
  logic ev_stat_rd, ev_data_wr, ev_data_rd, ev_pkt_done;
  logic ev_rsp_ok, ev_pio_start, ev_dma_start;
  logic ev_pio_end, ev_blk_edge, ev_dma_req, ev_dma_end;
  logic irq_raise, irq_clear, irq_pending, irq_set_edge;
  logic [BC_W-1:0] dma_gnt;
  logic [15:0]     buf_word;

  assign host_cmd   = reg_wr && (reg_addr == A_CMD);
  assign ev_abort   = host_cmd && (reg_wdata[7:0] == OP_ABORT);
  assign ev_packet  = host_cmd && (reg_wdata[7:0] == OP_PACKET);
  assign ev_unimpl  = host_cmd && !ev_abort && !ev_packet;
  assign ev_stat_rd = reg_rd && (reg_addr == A_CMD);

  assign ev_data_wr  = reg_wr && (reg_addr == A_DATA) && (state_q == S_CMDW);
  assign ev_pkt_done = ev_data_wr && adc_reached(ofs_q, TWO, BC_W'(PKT_BYTES));

  assign ev_data_rd  = reg_rd && (reg_addr == A_DATA) && (state_q == S_PIO);
  assign ev_pio_end  = ev_data_rd && adc_reached(ofs_q, TWO, len_q);
  assign ev_blk_edge = ev_data_rd && !ev_pio_end && (blk_left_q <= TWO);

  assign ev_rsp_ok    = (state_q == S_BUSY) && !host_cmd;
  assign ev_pio_start = ev_rsp_ok && rsp_pio;
  assign ev_dma_start = ev_rsp_ok && rsp_dma && !rsp_pio;

  assign ev_dma_req = dma_req && (state_q == S_DMA) && !host_cmd;
  assign dma_gnt    = adc_grant(dma_req_len, len_q - ofs_q);
  assign ev_dma_end = ev_dma_req && adc_reached(ofs_q, dma_gnt, len_q);

  assign irq_raise = ev_abort || ev_pio_start || ev_dma_start ||
                     ev_pio_end || ev_blk_edge || ev_dma_end;
  assign irq_clear = host_cmd || (ev_stat_rd && !status_q[7]);

  adc_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (irq_raise),
    .clear    (irq_clear),
    .mask     (ctrl_q[1]),
    .pending  (irq_pending),
    .set_edge (irq_set_edge),
    .line     (intrq)
  );

  adc_sector_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk     (clk),
    .wr_en   (ld_we),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (ofs_q[AW:1]),
    .rd_data (buf_word)
  );

  // command / transfer state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      status_q   <= ST_DRDY | ST_SERV;
      error_q    <= '0;
      count_q    <= '0;
      bcl_q      <= '0;
      bch_q      <= '0;
      ofs_q      <= '0;
      len_q      <= '0;
      blk_len_q  <= '0;
      blk_left_q <= '0;
    end else if (host_cmd) begin
      if (ev_abort) begin
        state_q  <= S_IDLE;
        status_q <= ST_DRDY | ST_SERV | ST_CHK;
        ofs_q    <= '0;
      end else if (ev_packet) begin
        state_q  <= S_CMDW;
        status_q <= ST_DRDY | ST_DRQ;
        error_q  <= {6'b0, feature_q[1:0]};
        count_q  <= CNT_COD;
        ofs_q    <= '0;
      end else begin
        status_q <= adc_unimpl_status(status_q);
      end
    end else begin
      if (reg_wr && reg_addr == A_CNT) count_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_BCL) bcl_q   <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_BCH) bch_q   <= reg_wdata[7:0];
      unique case (state_q)
        S_CMDW: if (ev_data_wr) begin
          if (ev_pkt_done) begin
            state_q  <= S_BUSY;
            status_q <= (status_q & ~ST_DRQ) | ST_BSY;
            ofs_q    <= '0;
          end else begin
            ofs_q <= ofs_q + TWO;
          end
        end
        S_BUSY: if (ev_pio_start) begin
          state_q    <= S_PIO;
          status_q   <= ST_DRDY | ST_DRQ;
          count_q    <= CNT_IO;
          bcl_q      <= rsp_len[7:0];
          bch_q      <= rsp_len[15:8];
          len_q      <= rsp_len;
          blk_len_q  <= {bch_q, bcl_q};
          blk_left_q <= {bch_q, bcl_q};
          ofs_q      <= '0;
        end else if (ev_dma_start) begin
          state_q  <= S_DMA;
          status_q <= ST_BSY | ST_DRDY | ST_SERV;
          count_q  <= CNT_IO;
          len_q    <= rsp_len;
          ofs_q    <= '0;
        end
        S_PIO: if (ev_data_rd) begin
          ofs_q <= ofs_q + TWO;
          if (ev_pio_end) begin
            state_q  <= S_IDLE;
            status_q <= status_q & ~ST_DRQ;
          end else if (ev_blk_edge) begin
            blk_left_q <= blk_len_q;
          end else begin
            blk_left_q <= blk_left_q - TWO;
          end
        end
        S_DMA: if (ev_dma_req) begin
          ofs_q <= ofs_q + dma_gnt;
          if (ev_dma_end) begin
            state_q  <= S_IDLE;
            status_q <= ST_DRDY | ST_SERV;
          end
        end
        default: ;
      endcase
    end
  end

  // host-owned registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feature_q <= '0;
      device_q  <= '0;
      ctrl_q    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_ERR) feature_q <= reg_wdata[7:0];
      if (reg_addr == A_DEV) device_q  <= reg_wdata[7:0];
      if (reg_addr == A_CTL) ctrl_q    <= reg_wdata[7:0];
    end
  end

  // packet capture
  for (genvar gi = 0; gi < PKT_WORDS; gi++) begin : g_pkt
    always_ff @(posedge clk) begin
      if (!rst_n) pkt_q[gi] <= '0;
      else if (ev_data_wr && ofs_q == BC_W'(2 * gi)) pkt_q[gi] <= reg_wdata;
    end
    assign pkt_data[16*gi +: 16] = pkt_q[gi];
  end

  // outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_valid_q <= 1'b0;
      dma_done_q  <= 1'b0;
      grant_q     <= '0;
    end else begin
      pkt_valid_q <= ev_pkt_done && !host_cmd;
      dma_done_q  <= ev_dma_end;
      grant_q     <= ev_dma_req ? dma_gnt : '0;
    end
  end

  assign pkt_valid     = pkt_valid_q;
  assign dma_done      = dma_done_q;
  assign dma_grant_len = grant_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_DATA:  reg_rdata = (state_q == S_PIO) ? buf_word : 16'h0;
        A_ERR:   reg_rdata = {8'h0, error_q};
        A_CNT:   reg_rdata = {8'h0, count_q};
        A_BCL:   reg_rdata = {8'h0, bcl_q};
        A_BCH:   reg_rdata = {8'h0, bch_q};
        A_DEV:   reg_rdata = {8'h0, device_q};
        A_CMD:   reg_rdata = {8'h0, status_q};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_checker.sv
module adc_checker
  import adc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [2:0] reg_addr,
  input logic [15:0] reg_wdata,
  input logic [7:0] status_q,
  input logic       pkt_valid,
  input logic       dma_done,
  input logic       irq_pending,
  input logic       intrq
);
  AST_PKT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> status_q == 8'hC0); // R3
  AST_PKT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R3
  AST_DMA_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> status_q == 8'h50 && irq_pending); // R7
  AST_DMA_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done); // R7
  AST_BSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CMD && status_q[7] && irq_pending &&
     !(reg_wr && reg_addr == A_CMD)) |=> irq_pending); // R8
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTL && reg_wdata[1]) |=> !intrq); // R9
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CMD && reg_wdata[7:0] == OP_ABORT)
      |=> status_q == 8'h51 && irq_pending); // R10
  AST_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CMD && reg_wdata[7:0] != OP_ABORT &&
     reg_wdata[7:0] != OP_PACKET) |=> !irq_pending && status_q[6] && status_q[4] && !status_q[0]); // R11
endmodule

bind atapi_dev_ctrl adc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .status_q    (status_q),
  .pkt_valid   (pkt_valid),
  .dma_done    (dma_done),
  .irq_pending (irq_pending),
  .intrq       (intrq)
);

// File: tb/atapi_dev_ctrl_bench.sv
module atapi_dev_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        ld_we = 0;
  logic [5:0]  ld_addr = 0;
  logic [15:0] ld_data = 0;
  logic        pkt_valid;
  logic [95:0] pkt_data;
  logic        rsp_pio = 0, rsp_dma = 0;
  logic [15:0] rsp_len = 0;
  logic        dma_req = 0;
  logic [15:0] dma_req_len = 0;
  logic [15:0] dma_grant_len;
  logic        dma_done;
  logic        intrq;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  atapi_dev_ctrl u_atapi_dev_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .rsp_pio(rsp_pio), .rsp_dma(rsp_dma), .rsp_len(rsp_len),
    .dma_req(dma_req), .dma_req_len(dma_req_len),
    .dma_grant_len(dma_grant_len), .dma_done(dma_done), .intrq(intrq)
  );

  // {expected intrq, command code, expected status}
  localparam logic [16:0] CMD_VEC [6] = '{
    {1'b1, 8'h00, 8'h51}, {1'b0, 8'hEF, 8'h50}, {1'b1, 8'h00, 8'h51},
    {1'b0, 8'h90, 8'h50}, {1'b0, 8'hEC, 8'h50}, {1'b1, 8'h00, 8'h51}
  };

  function automatic logic [15:0] pattern(input int i);
    return 16'hA500 ^ (16'(i) * 16'h0103);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic respond(input logic pio, input logic [15:0] len);
    @(negedge clk);
    rsp_pio = pio; rsp_dma = !pio; rsp_len = len;
    @(posedge clk); #1;
    rsp_pio = 0; rsp_dma = 0;
  endtask

  task automatic dreq(input logic [15:0] len);
    @(negedge clk);
    dma_req = 1; dma_req_len = len;
    @(posedge clk); #1;
    dma_req = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 intrq", intrq, 0);
    rd(3'd6, v); chk("R1 status", v, 16'h50);
    rd(3'd5, v); chk("R1 device", v, 0);
    rd(3'd1, v); chk("R1 error", v, 0);

    // load the sector buffer
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = 6'(i); ld_data = pattern(i);
    end
    @(negedge clk) ld_we = 0;

    // R12 data read in idle returns zero
    rd(3'd0, v); chk("R12 idle data read", v, 0);

    // R10 R11 command table
    for (int i = 0; i < 6; i++) begin
      wr(3'd6, {8'h0, CMD_VEC[i][15:8]});
      chk("R10/R11 intrq", intrq, CMD_VEC[i][16]);
      rd(3'd6, v); chk("R10/R11 status", v, {8'h0, CMD_VEC[i][7:0]});
      if (CMD_VEC[i][16]) chk("R8 cleared by read", intrq, 0);
      if (i < 5 && CMD_VEC[i][16]) wr(3'd6, 16'h00EF);
    end
    // make pending again for the mask test
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0002); chk("R9 masked", intrq, 0);
    wr(3'd7, 16'h0000); chk("R9 unmasked", intrq, 1);

    // R12 stray write in idle must not shorten the packet window
    wr(3'd0, 16'h1111);
    // R2 packet command with block length 4
    wr(3'd3, 16'h0004); wr(3'd4, 16'h0000);
    wr(3'd1, 16'h0002);
    wr(3'd6, 16'h00A0);
    chk("R10 command clears pending", intrq, 0);
    rd(3'd6, v); chk("R2 status", v, 16'h48);
    rd(3'd1, v); chk("R2 error", v, 16'h02);
    rd(3'd2, v); chk("R2 count", v, 16'h01);
    for (int k = 0; k < 5; k++) wr(3'd0, 16'h3000 + 16'(k));
    chk("R12 window still open", pkt_valid, 0);
    rd(3'd6, v); chk("R12 status after 5 words", v, 16'h48);
    wr(3'd0, 16'h3005);
    chk("R3 pkt_valid", pkt_valid, 1);
    chk("R3 pkt word0", pkt_data[15:0], 16'h3000);
    chk("R3 pkt word5", pkt_data[95:80], 16'h3005);
    @(posedge clk); #1;
    chk("R3 pkt_valid one cycle", pkt_valid, 0);
    rd(3'd6, v); chk("R3 status busy", v, 16'hC0);

    // R4 start PIO read of 10 bytes
    respond(1'b1, 16'd10);
    chk("R4 intrq", intrq, 1);
    rd(3'd3, v); chk("R4 bcnt low", v, 16'd10);
    rd(3'd4, v); chk("R4 bcnt high", v, 0);
    rd(3'd2, v); chk("R4 count", v, 16'h02);
    rd(3'd6, v); chk("R4 status", v, 16'h48);
    chk("R8 status read clears", intrq, 0);

    // R5 R6 five words, block 4 bytes: boundaries after words 1 and 3
    for (int w = 0; w < 5; w++) begin
      rd(3'd0, v); chk("R5 data word", v, pattern(w));
      chk("R5/R6 interrupt", intrq, (w == 1 || w == 3 || w == 4) ? 1'b1 : 1'b0);
      if (w != 4) begin
        rd(3'd6, v); chk("R5 status during read", v, 16'h48);
      end
    end
    rd(3'd6, v); chk("R6 end status", v, 16'h40);
    rd(3'd0, v); chk("R6 idle after read", v, 0);

    // R7 DMA read of 20 bytes
    wr(3'd1, 16'h0001);
    wr(3'd6, 16'h00A0);
    rd(3'd1, v); chk("R2 error from feature", v, 16'h01);
    for (int k = 0; k < 6; k++) wr(3'd0, 16'h4000 + 16'(k));
    respond(1'b0, 16'd20);
    chk("R7 intrq on start", intrq, 1);
    rd(3'd6, v); chk("R7 dma status", v, 16'hD0);
    chk("R8 busy read keeps pending", intrq, 1);
    dreq(16'd8);
    chk("R7 grant 8", dma_grant_len, 16'd8);
    chk("R7 no done yet", dma_done, 0);
    dreq(16'd16);
    chk("R7 grant clamped", dma_grant_len, 16'd12);
    chk("R7 done pulse", dma_done, 1);
    @(posedge clk); #1;
    chk("R7 done one cycle", dma_done, 0);
    rd(3'd6, v); chk("R7 final status", v, 16'h50);
    chk("R8 cleared after DMA", intrq, 0);
    dreq(16'd4);
    chk("R12 request in idle", dma_grant_len, 0);

    // R10 abort during packet window
    wr(3'd6, 16'h00A0);
    wr(3'd0, 16'h5555);
    wr(3'd6, 16'h0000);
    chk("R10 abort intrq", intrq, 1);
    rd(3'd6, v); chk("R10 abort status", v, 16'h51);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule